// File: doc/BRIEF.md
# Debug Read/Write Access Target Unit

This unit sits behind a JTAG test access port and gives a debugger access to memory-mapped resources. It does not contain the TAP controller. It receives the controller's capture, shift and update strobes for the data register path, plus a level `access_en` that is high while the access-enable instruction is loaded. While `access_en` is high, the unit alternates between two kinds of scan. The first scan shifts in an 8-bit select code. The second scan reads or writes the 32-bit register that the code names. Bit 0 of the code chooses the direction: 1 writes the register and 0 captures it for reading.

The unit holds three registers: a control/status word, a bus address and a data word. A control write with the start bit set begins an access. In write direction, each later data-register write produces one bus write. In read direction, the first bus read is issued at once and each later read scan of the data register fetches the next word. A count above one turns the access into a block transfer. After every transfer, the address steps by the transfer size in bytes. The bus side is a simple request/ready handshake that carries an error flag on the response.

Top module: `dbg_acc_top`

## Requirements
- R1: Each pair of DR scans forms one access. The first scan shifts an 8-bit code into the unit, LSB first. The second scan shifts 32 bits, LSB first. `tdo` carries the captured value LSB first. The codes are 0x0E/0x0F for control, 0x12/0x13 for address and 0x14/0x15 for data, where an odd code writes at update and an even code only reads.
- R2: The control word reads back with start at bit 31, direction at bit 30 (1 = write), size at 29:27, map at 26:24, priority at 23:22 and remaining count at 15:2. Bits 21:16 read as zero.
- R3: Error (bit 1) and data-valid (bit 0) are status bits only. Values written to these two bits are ignored.
- R4: A select code outside the six listed codes makes the next data scan a 1-bit bypass. In that scan, `tdo` shows the previous `tdi` bit and 0 on the first shift. No register changes, and the unit then returns to expecting a select scan.
- R5: While `access_en` is low, capture, shift and update strobes have no effect on any register or on the scan phase.
- R6: A control write with start=1 and direction=write issues no bus request by itself. Each data-register write made while start is set issues one bus write of that data at the current address.
- R7: A control write with start=1 and direction=read issues a bus read at once. The returned word is latched into the data register and sets data-valid. A read capture of the data register clears data-valid and, if start is still set, issues the next bus read.
- R8: Size codes 0, 1, 2 and 3 are driven on `bus_size` and select transfers of 1, 2, 4 and 8 bytes. After each successful transfer, the address register advances by that many bytes.
- R9: Each successful transfer decrements the remaining count. Start clears when the count reaches zero, so a count of N moves exactly N words.
- R10: An error response sets the error bit, clears start and the count, and leaves the address unchanged. After that, data writes cause no bus traffic. The next control write with start=1 clears the error bit.
- R11: Once raised, `bus_req` stays high, with address and direction stable, until the cycle in which `bus_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_en | input | 1 | Access-enable instruction active in the TAP |
| capture_dr | input | 1 | Capture-DR strobe, one cycle |
| shift_dr | input | 1 | Shift-DR strobe, one cycle per bit |
| update_dr | input | 1 | Update-DR strobe, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (registered) |
| bus_req | output | 1 | Bus request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_size | output | 2 | Transfer size code (0..3 = 1..8 bytes) |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ready |
| bus_ready | input | 1 | Transfer complete |
| bus_err | input | 1 | Error response, valid with ready |

## Verification
The hardest state to reach from the ports is a block read in progress. In that state, a bus read has already been prefetched and the next read must be started by the read capture of the data register itself. The stimulus writes known words with 16-bit block writes, then starts a two-word read and interleaves data-register read scans with waits. The scoreboard can then tie each prefetch to the scan that caused it and confirm that no third request appears. The error path is reached by aiming a block write at an address the bus model rejects. The bench then confirms that later data writes stay off the bus and that only a start write clears the error bit.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

  localparam int CTRL_W = 32;
  localparam int CNT_W  = 14;

  // Register selected by the code in bits [7:1]; bit 0 means write.
  localparam logic [6:0] CODE_CTRL = 7'h07;
  localparam logic [6:0] CODE_ADDR = 7'h09;
  localparam logic [6:0] CODE_DATA = 7'h0A;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_CTRL,
    REG_ADDR,
    REG_DATA
  } reg_sel_e;

  typedef struct packed {
    logic             start;
    logic             dir_wr;
    logic [2:0]       size;
    logic [2:0]       map;
    logic [1:0]       prio;
    logic [5:0]       rsvd;
    logic [CNT_W-1:0] cnt;
    logic             err;
    logic             dv;
  } ctrl_t;

  function automatic reg_sel_e decode_sel(input logic [7:0] code);
    case (code[7:1])
      CODE_CTRL: return REG_CTRL;
      CODE_ADDR: return REG_ADDR;
      CODE_DATA: return REG_DATA;
      default:   return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_acc_scan.sv
module dbg_acc_scan
  import dbg_acc_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              access_en,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_val,
  output logic              tdo,
  output reg_sel_e          sel,
  output logic              wr_pulse,
  output logic              rd_pulse,
  output logic [DATA_W-1:0] wr_data
);

  logic              phase_data;
  logic [SEL_W-1:0]  code_q;
  logic [DATA_W-1:0] sr;

  assign sel = decode_sel(code_q);
  assign tdo = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_data <= 1'b0;
      code_q     <= '0;
      sr         <= '0;
      wr_pulse   <= 1'b0;
      rd_pulse   <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_pulse <= 1'b0;
      rd_pulse <= 1'b0;
      if (access_en) begin
        if (capture_dr) begin
          if (!phase_data || sel == REG_NONE) begin
            sr <= '0;
          end else begin
            sr <= cap_val;
            rd_pulse <= ~code_q[0];
          end
        end else if (shift_dr) begin
          if (!phase_data) begin
            sr[SEL_W-1:0] <= {tdi, sr[SEL_W-1:1]};
          end else if (sel == REG_NONE) begin
            sr[0] <= tdi;
          end else begin
            sr <= {tdi, sr[DATA_W-1:1]};
          end
        end else if (update_dr) begin
          if (!phase_data) begin
            code_q     <= sr[SEL_W-1:0];
            phase_data <= 1'b1;
          end else begin
            phase_data <= 1'b0;
            if (sel != REG_NONE && code_q[0]) begin
              wr_pulse <= 1'b1;
              wr_data  <= sr;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/dbg_acc_engine.sv
module dbg_acc_engine
  import dbg_acc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_sel_e          sel,
  input  logic              wr_pulse,
  input  logic              rd_pulse,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);

  ctrl_t             wr_ctrl;
  logic [ADDR_W-1:0] step;
  logic              last_beat;

  assign wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign last_beat = (ctrl_q.cnt <= CNT_W'(1));

  always_comb begin
    step = ADDR_W'(1) << ctrl_q.size[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
    end else if (bus_req) begin
      if (bus_ready) begin
        bus_req <= 1'b0;
        if (bus_err) begin
          ctrl_q.err   <= 1'b1;
          ctrl_q.start <= 1'b0;
          ctrl_q.cnt   <= '0;
        end else begin
          addr_q     <= addr_q + step;
          ctrl_q.cnt <= (ctrl_q.cnt == '0) ? '0 : ctrl_q.cnt - CNT_W'(1);
          if (last_beat) ctrl_q.start <= 1'b0;
          if (!bus_we) begin
            data_q    <= bus_rdata;
            ctrl_q.dv <= 1'b1;
          end
        end
      end
    end else if (wr_pulse) begin
      case (sel)
        REG_CTRL: begin
          ctrl_q.start  <= wr_ctrl.start;
          ctrl_q.dir_wr <= wr_ctrl.dir_wr;
          ctrl_q.size   <= wr_ctrl.size;
          ctrl_q.map    <= wr_ctrl.map;
          ctrl_q.prio   <= wr_ctrl.prio;
          ctrl_q.cnt    <= wr_ctrl.cnt;
          if (wr_ctrl.start) ctrl_q.err <= 1'b0;
          if (wr_ctrl.start && !wr_ctrl.dir_wr) begin
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= addr_q;
            bus_size <= wr_ctrl.size[1:0];
          end
        end
        REG_ADDR: addr_q <= ADDR_W'(wr_data);
        REG_DATA: begin
          data_q <= wr_data;
          if (ctrl_q.start && ctrl_q.dir_wr) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= addr_q;
            bus_size  <= ctrl_q.size[1:0];
            bus_wdata <= wr_data;
          end
        end
        default: ;
      endcase
    end else if (rd_pulse && sel == REG_DATA) begin
      ctrl_q.dv <= 1'b0;
      if (ctrl_q.start && !ctrl_q.dir_wr) begin
        bus_req  <= 1'b1;
        bus_we   <= 1'b0;
        bus_addr <= addr_q;
        bus_size <= ctrl_q.size[1:0];
      end
    end
  end

endmodule

// File: rtl/dbg_acc_top.sv
module dbg_acc_top
  import dbg_acc_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              access_en,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);

  reg_sel_e          sel;
  logic              scan_wr;
  logic              scan_rd;
  logic [DATA_W-1:0] scan_data;
  logic [DATA_W-1:0] cap_val;
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              start_flag;
  logic              err_flag;
  logic              dv_flag;

  assign start_flag = ctrl_q.start;
  assign err_flag   = ctrl_q.err;
  assign dv_flag    = ctrl_q.dv;

  always_comb begin
    case (sel)
      REG_CTRL: cap_val = DATA_W'({ctrl_q.start, ctrl_q.dir_wr, ctrl_q.size, ctrl_q.map,
                                   ctrl_q.prio, 6'b0, ctrl_q.cnt, ctrl_q.err, ctrl_q.dv});
      REG_ADDR: cap_val = DATA_W'(addr_q);
      REG_DATA: cap_val = data_q;
      default:  cap_val = '0;
    endcase
  end

  dbg_acc_scan #(.SEL_W(SEL_W), .DATA_W(DATA_W)) scan_i (
    .clk(clk), .rst(rst), .access_en(access_en),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .cap_val(cap_val), .tdo(tdo), .sel(sel),
    .wr_pulse(scan_wr), .rd_pulse(scan_rd), .wr_data(scan_data)
  );

  dbg_acc_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) engine_i (
    .clk(clk), .rst(rst), .sel(sel),
    .wr_pulse(scan_wr), .rd_pulse(scan_rd), .wr_data(scan_data),
    .ctrl_q(ctrl_q), .addr_q(addr_q), .data_q(data_q),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err)
  );

endmodule

// File: rtl/dbg_acc_chk.sv
module dbg_acc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              access_en,
  input logic              scan_wr,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ready,
  input logic              bus_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] addr_q,
  input logic              start_flag,
  input logic              err_flag,
  input logic              dv_flag
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  // R9
  req_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> start_flag);

  // R10
  err_from_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(bus_req && bus_ready && bus_err));

  // R7
  dv_from_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dv_flag) |-> $past(bus_req && bus_ready && !bus_we));

  // R5
  idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !access_en && !bus_req && !scan_wr |=> $stable(addr_q));

endmodule

bind dbg_acc_top dbg_acc_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .access_en(access_en), .scan_wr(scan_wr),
  .bus_req(bus_req), .bus_we(bus_we), .bus_ready(bus_ready), .bus_err(bus_err),
  .bus_addr(bus_addr), .addr_q(addr_q), .start_flag(start_flag),
  .err_flag(err_flag), .dv_flag(dv_flag)
);

// File: tb/dbg_acc_top_tb_top.sv
module dbg_acc_top_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        access_en = 1'b1;
  logic        capture_dr = 1'b0;
  logic        shift_dr = 1'b0;
  logic        update_dr = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        bus_req;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        bus_err = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
  } txn_t;
  txn_t exp_q[$];

  logic [31:0] mem [64];
  int lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_acc_top dut_i (
    .clk(clk), .rst(rst), .access_en(access_en),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Bus model and monitor: answers each request after a fixed latency and
  // compares it with the next expected transfer.
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      bus_err   = 1'b0;
      lat       = 0;
    end else if (bus_req) begin
      if (lat == 2) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected bus request", bus_addr, 32'hFFFF_FFFF);
        end else begin
          txn_t t;
          t = exp_q.pop_front();
          check("R1 bus direction", {31'b0, bus_we}, {31'b0, t.we});
          check("R8 bus address", bus_addr, t.addr);
          check("R8 bus size", {30'b0, bus_size}, {30'b0, t.size});
          if (t.we) check("R6 bus write data", bus_wdata, t.wdata);
        end
        bus_err   = bus_addr[31];
        bus_rdata = mem[bus_addr[7:2]];
        if (bus_we && !bus_addr[31]) mem[bus_addr[7:2]] = bus_wdata;
        bus_ready = 1'b1;
      end else begin
        lat++;
      end
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [1:0] s,
                      input logic [31:0] d);
    txn_t t;
    t.we = we; t.addr = a; t.size = s; t.wdata = d;
    exp_q.push_back(t);
  endtask

  function automatic logic [31:0] mk(input logic st, input logic wr,
                                     input logic [2:0] sz, input logic [13:0] c);
    return {st, wr, sz, 3'b000, 2'b11, 6'b0, c, 2'b00};
  endfunction

  task automatic scan_sel(input logic [7:0] code);
    @(negedge clk) capture_dr = 1'b1;
    @(negedge clk) capture_dr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      shift_dr = 1'b1; tdi = code[i];
      @(negedge clk);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge clk) update_dr = 1'b0;
  endtask

  task automatic scan_dat(input logic [31:0] w, output logic [31:0] r);
    @(negedge clk) capture_dr = 1'b1;
    @(negedge clk) capture_dr = 1'b0;
    for (int i = 0; i < 32; i++) begin
      r[i] = tdo;
      shift_dr = 1'b1; tdi = w[i];
      @(negedge clk);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge clk) update_dr = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] code, input logic [31:0] v);
    logic [31:0] dummy;
    scan_sel(code);
    scan_dat(v, dummy);
  endtask

  task automatic reg_rd(input logic [7:0] code, output logic [31:0] v);
    scan_sel(code);
    scan_dat(32'h0, v);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    check("R11 bus_req after reset", {31'b0, bus_req}, 32'h0);
    check("R1 tdo after reset", {31'b0, tdo}, 32'h0);
    reg_rd(8'h0E, v); check("R2 ctrl reset value", v, 32'h0);

    // R1: address register write and read back
    reg_wr(8'h13, 32'h0000_0040);
    reg_rd(8'h12, v); check("R1 address readback", v, 32'h40);

    // R6: single write waits for data
    reg_wr(8'h0F, mk(1, 1, 3'd2, 14'd1));
    settle();
    check("R6 no request before data", {31'b0, bus_req}, 32'h0);
    reg_rd(8'h0E, v); check("R2 ctrl fields readback", v, mk(1, 1, 3'd2, 14'd1));
    push(1, 32'h40, 2'd2, 32'hA5A5_0001);
    reg_wr(8'h15, 32'hA5A5_0001);
    settle();
    reg_rd(8'h0E, v); check("R9 start cleared after single", v, mk(0, 1, 3'd2, 14'd0));
    reg_rd(8'h12, v); check("R8 address step 4", v, 32'h44);

    // R3: status bits not writable
    reg_wr(8'h0F, mk(0, 1, 3'd2, 14'd0) | 32'h3);
    reg_rd(8'h0E, v); check("R3 status write ignored", v, mk(0, 1, 3'd2, 14'd0));

    // R9 / R8: 16-bit block write of three words
    reg_wr(8'h13, 32'h0000_0080);
    reg_wr(8'h0F, mk(1, 1, 3'd1, 14'd3));
    for (int i = 0; i < 3; i++) begin
      push(1, 32'h80 + 32'(2 * i), 2'd1, 32'h1111_0000 + 32'(i));
      reg_wr(8'h15, 32'h1111_0000 + 32'(i));
      settle();
      if (i == 0) begin
        reg_rd(8'h0E, v); check("R9 count decrements", v, mk(1, 1, 3'd1, 14'd2));
      end
    end
    reg_rd(8'h0E, v); check("R9 block write done", v, mk(0, 1, 3'd1, 14'd0));
    reg_rd(8'h12, v); check("R8 address step 2", v, 32'h86);

    // R8: 8-bit block of two
    reg_wr(8'h13, 32'h0000_0010);
    reg_wr(8'h0F, mk(1, 1, 3'd0, 14'd2));
    push(1, 32'h10, 2'd0, 32'h22);
    reg_wr(8'h15, 32'h22); settle();
    push(1, 32'h11, 2'd0, 32'h33);
    reg_wr(8'h15, 32'h33); settle();
    reg_rd(8'h12, v); check("R8 address step 1", v, 32'h12);

    // R8: 64-bit single
    reg_wr(8'h13, 32'h0000_0020);
    reg_wr(8'h0F, mk(1, 1, 3'd3, 14'd1));
    push(1, 32'h20, 2'd3, 32'h4444_5555);
    reg_wr(8'h15, 32'h4444_5555); settle();
    reg_rd(8'h12, v); check("R8 address step 8", v, 32'h28);

    // R7: single read
    reg_wr(8'h13, 32'h0000_0040);
    push(0, 32'h40, 2'd2, 32'h0);
    reg_wr(8'h0F, mk(1, 0, 3'd2, 14'd1));
    settle();
    reg_rd(8'h0E, v); check("R7 data valid set", v, mk(0, 0, 3'd2, 14'd0) | 32'h1);
    reg_rd(8'h14, v); check("R7 read data", v, 32'hA5A5_0001);
    reg_rd(8'h0E, v); check("R7 data valid cleared", v, mk(0, 0, 3'd2, 14'd0));

    // R9 / R7: block read of two words with prefetch per data capture
    reg_wr(8'h13, 32'h0000_0080);
    push(0, 32'h80, 2'd2, 32'h0);
    reg_wr(8'h0F, mk(1, 0, 3'd2, 14'd2));
    settle();
    push(0, 32'h84, 2'd2, 32'h0);
    reg_rd(8'h14, v); check("R9 block read word 0", v, 32'h1111_0001);
    settle();
    reg_rd(8'h14, v); check("R9 block read word 1", v, 32'h1111_0002);
    settle();
    check("R9 no extra read", {31'b0, bus_req}, 32'h0);
    check("R9 all reads seen", 32'(exp_q.size()), 32'h0);
    reg_rd(8'h0E, v); check("R9 block read done", v, mk(0, 0, 3'd2, 14'd0));

    // R10: bus error aborts
    reg_wr(8'h13, 32'h8000_0000);
    reg_wr(8'h0F, mk(1, 1, 3'd2, 14'd3));
    push(1, 32'h8000_0000, 2'd2, 32'h1234);
    reg_wr(8'h15, 32'h1234); settle();
    reg_rd(8'h0E, v); check("R10 error set and aborted", v, mk(0, 1, 3'd2, 14'd0) | 32'h2);
    reg_rd(8'h12, v); check("R10 address held on error", v, 32'h8000_0000);
    reg_wr(8'h15, 32'h5678); settle();
    check("R10 no traffic after abort", 32'(exp_q.size()), 32'h0);
    reg_wr(8'h0F, mk(0, 1, 3'd2, 14'd0));
    reg_rd(8'h0E, v); check("R3 error not cleared by write", v, mk(0, 1, 3'd2, 14'd0) | 32'h2);
    reg_wr(8'h13, 32'h0000_0040);
    reg_wr(8'h0F, mk(1, 1, 3'd2, 14'd1));
    reg_rd(8'h0E, v); check("R10 start clears error", v, mk(1, 1, 3'd2, 14'd1));
    push(1, 32'h40, 2'd2, 32'hA5A5_0001);
    reg_wr(8'h15, 32'hA5A5_0001); settle();

    // R4: unknown code gives 1-bit bypass
    scan_sel(8'h20);
    scan_dat(32'hC3A5_00B5, v);
    check("R4 bypass delay", v, 32'hC3A5_00B5 << 1);
    reg_rd(8'h12, v); check("R4 registers untouched", v, 32'h44);

    // R5: scans ignored while access disabled
    @(negedge clk) access_en = 1'b0;
    reg_wr(8'h13, 32'h0000_DEAD);
    @(negedge clk) access_en = 1'b1;
    reg_rd(8'h12, v); check("R5 address unchanged", v, 32'h44);

    settle();
    check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule